// File: doc/BRIEF.md
# Cyclic Egress Gate Scheduler

This block opens and closes the eight per-traffic-class transmit gates of one egress port according to a cyclic gate-control list. Each list entry holds a gate mask (bit n opens the gate of class n) and a hold time counted in 200 ns slots. Time comes from a synchronized clock that has already been quantized into slots: the block sees the absolute slot number and a one-cycle strobe at the start of each slot. Gate changes therefore happen only on slot boundaries.

Software writes the list, the number of active entries, the absolute start slot and a run bit through a simple write-only register port. Once armed, the block holds every gate open until the start slot is reached, then walks the list entry by entry and wraps back to the first entry after the last, so the cycle time is the sum of the intervals (for example 2500 slots of class 7 only followed by 2000... any mix the list describes). Edits made while the schedule runs land in a shadow copy and take over only at the next cycle boundary.

All gate events of the engine share one slot timeline with other ports and ingress schedules. The block publishes a pulse for each of its own gate events, samples a peer-event input, and records in a sticky flag any slot in which both fired. A zero hold time is illegal; it is flagged and executed as one slot.

Top module: `tas_egress_gate_sched`

## Requirements
- R1: After reset all gates are open (`gate_open` = 8'hFF), `running`, `gate_evt`, `err_zero_ivl` and `err_collision` are 0 and `cur_entry` is 0.
- R2: While the run bit is 0, or before a slot strobe arrives with `now_slot` >= the programmed start slot, all gates stay open and `running` is 0; on the first strobe with `now_slot` >= start slot the schedule starts at entry 0, and `running` and the entry-0 mask appear one clock after that strobe.
- R3: `gate_open` equals the mask of the current entry; bit n set opens the gate of traffic class n.
- R4: An entry with interval I (slots) stays in force for exactly I slot strobes counting its own load strobe; `gate_open` never changes on a clock that follows a cycle without a strobe while the run bit is 1.
- R5: After the last active entry (count set through the length register) the list wraps to entry 0; `cur_entry` shows the index of the entry in force.
- R6: Writes to list entries or to the length register while running do not alter the cycle in progress; they take effect from the next wrap to entry 0 (or the next start).
- R7: Loading an entry whose interval is 0 sets the sticky flag `err_zero_ivl`; that entry is held for one slot.
- R8: When `peer_gate_evt` is high on a strobe cycle in which this block fires a gate event, the sticky flag `err_collision` is set; a peer event in a slot with no local event has no effect.
- R9: `gate_evt` is a one-clock pulse, one clock after each strobe that starts the schedule or moves to another entry.
- R10: Clearing the run bit returns all gates to open and `running` to 0 within two clocks of the write; setting it again waits for the start slot and restarts at entry 0.
- R11: Register map (32-bit data, default parameters): address 0..15 is list entry k with mask in data[7:0] and interval in data[23:8]; address 16 holds the run bit in data[0]; address 17 holds the active entry count minus one in data[3:0]; address 18 holds the start slot in data[31:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_strobe | input | 1 | One-clock pulse at the start of each 200 ns slot |
| now_slot | input | TIME_W | Absolute slot number from the synchronized clock |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | ADDR_W | Register address |
| cfg_wdata | input | 32 | Register write data |
| peer_gate_evt | input | 1 | A gate event elsewhere on the shared timeline in this slot |
| gate_open | output | NUM_TC | Per-class gate state, 1 = open |
| gate_evt | output | 1 | Pulse for each local gate event |
| cur_entry | output | IDX_W | Index of the entry in force |
| running | output | 1 | Schedule has started |
| err_zero_ivl | output | 1 | Sticky: a zero interval was loaded |
| err_collision | output | 1 | Sticky: local and peer events shared a slot |

## Verification
On every cycle the assertions check that the gates stay frozen between strobes, that the event pulse only follows a strobe, that the entry index stays inside the active length, that the remaining-slot count never reaches zero while running, that the schedule cannot start before the start slot, that both error flags are sticky, and that the active length changes only at a commit. Only the bench scenarios can show the actual gate sequence over whole cycles, the exact slot of each change, the deferral of a mid-cycle list rewrite to the next boundary, the one-slot handling of a zero interval, and the restart after the run bit is cleared.

// File: rtl/tas_pkg.sv
package tas_pkg;
  // Hold time actually executed for a programmed interval: zero runs as one slot.
  function automatic logic [31:0] eff_slots(input logic [31:0] ivl);
    eff_slots = (ivl == 32'd0) ? 32'd1 : ivl;
  endfunction

  // Index that follows idx in a list whose last index is last_idx.
  function automatic logic [31:0] follow_idx(input logic [31:0] idx, input logic [31:0] last_idx);
    follow_idx = (idx >= last_idx) ? 32'd0 : idx + 32'd1;
  endfunction
endpackage

// File: rtl/tas_gcl_shadow.sv
module tas_gcl_shadow #(
  parameter int NUM_TC      = 8,
  parameter int MAX_ENTRIES = 16,
  parameter int IVL_W       = 16,
  parameter int TIME_W      = 32,
  localparam int IDX_W      = $clog2(MAX_ENTRIES),
  localparam int ADDR_W     = IDX_W + 1
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cfg_we,
  input  logic [ADDR_W-1:0]                    cfg_addr,
  input  logic [31:0]                          cfg_wdata,
  output logic [MAX_ENTRIES-1:0][NUM_TC-1:0]   sh_mask,
  output logic [MAX_ENTRIES-1:0][IVL_W-1:0]    sh_ivl,
  output logic [IDX_W-1:0]                     sh_len_m1,
  output logic                                 run_en,
  output logic [TIME_W-1:0]                    base_slot
);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(MAX_ENTRIES);
  localparam logic [ADDR_W-1:0] A_LEN  = ADDR_W'(MAX_ENTRIES + 1);
  localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(MAX_ENTRIES + 2);

  logic entry_space;
  assign entry_space = cfg_we && !cfg_addr[ADDR_W-1];

  for (genvar k = 0; k < MAX_ENTRIES; k++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh_mask[k] <= '1;
        sh_ivl[k]  <= IVL_W'(1);
      end else if (entry_space && cfg_addr[IDX_W-1:0] == IDX_W'(k)) begin
        sh_mask[k] <= cfg_wdata[NUM_TC-1:0];
        sh_ivl[k]  <= cfg_wdata[NUM_TC +: IVL_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_en    <= 1'b0;
      sh_len_m1 <= '0;
      base_slot <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == A_CTL)  run_en    <= cfg_wdata[0];
      if (cfg_addr == A_LEN)  sh_len_m1 <= cfg_wdata[IDX_W-1:0];
      if (cfg_addr == A_BASE) base_slot <= cfg_wdata[TIME_W-1:0];
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata;
endmodule

// File: rtl/tas_gcl_active.sv
module tas_gcl_active #(
  parameter int NUM_TC      = 8,
  parameter int MAX_ENTRIES = 16,
  parameter int IVL_W       = 16,
  localparam int IDX_W      = $clog2(MAX_ENTRIES)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               commit,
  input  logic [MAX_ENTRIES-1:0][NUM_TC-1:0] sh_mask,
  input  logic [MAX_ENTRIES-1:0][IVL_W-1:0]  sh_ivl,
  input  logic [IDX_W-1:0]                   sh_len_m1,
  output logic [MAX_ENTRIES-1:0][NUM_TC-1:0] act_mask,
  output logic [MAX_ENTRIES-1:0][IVL_W-1:0]  act_ivl,
  output logic [IDX_W-1:0]                   act_len_m1
);
  for (genvar k = 0; k < MAX_ENTRIES; k++) begin : g_copy
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        act_mask[k] <= '1;
        act_ivl[k]  <= IVL_W'(1);
      end else if (commit) begin
        act_mask[k] <= sh_mask[k];
        act_ivl[k]  <= sh_ivl[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      act_len_m1 <= '0;
    else if (commit) act_len_m1 <= sh_len_m1;
  end

  // R6: the active length follows the shadow only at a commit
  p_commit_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> act_len_m1 == $past(sh_len_m1));
  p_hold_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(act_len_m1));
endmodule

// File: rtl/tas_gate_engine.sv
module tas_gate_engine #(
  parameter int NUM_TC      = 8,
  parameter int MAX_ENTRIES = 16,
  parameter int IVL_W       = 16,
  parameter int TIME_W      = 32,
  localparam int IDX_W      = $clog2(MAX_ENTRIES)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               run_en,
  input  logic                               slot_strobe,
  input  logic [TIME_W-1:0]                  now_slot,
  input  logic [TIME_W-1:0]                  base_slot,
  input  logic                               peer_gate_evt,
  input  logic [NUM_TC-1:0]                  first_mask,
  input  logic [IVL_W-1:0]                   first_ivl,
  input  logic [MAX_ENTRIES-1:0][NUM_TC-1:0] act_mask,
  input  logic [MAX_ENTRIES-1:0][IVL_W-1:0]  act_ivl,
  input  logic [IDX_W-1:0]                   act_len_m1,
  output logic                               commit,
  output logic [NUM_TC-1:0]                  gate_open_q,
  output logic                               evt_q,
  output logic [IDX_W-1:0]                   idx_q,
  output logic                               run_q,
  output logic                               err_zero_q,
  output logic                               err_col_q
);
  logic [IVL_W-1:0]  remain_q;
  logic              start_c, step_c, wrap_c, fire_c;
  logic [IDX_W-1:0]  nidx;
  logic [NUM_TC-1:0] lmask;
  logic [IVL_W-1:0]  livl;

  always_comb begin
    start_c = run_en && !run_q && slot_strobe && (now_slot >= base_slot);
    step_c  = run_en && run_q && slot_strobe && (remain_q == IVL_W'(1));
    wrap_c  = step_c && (idx_q == act_len_m1);
    commit  = start_c || wrap_c;
    fire_c  = start_c || step_c;
    nidx    = commit ? '0 : IDX_W'(tas_pkg::follow_idx(32'(idx_q), 32'(act_len_m1)));
    lmask   = commit ? first_mask : act_mask[nidx];
    livl    = commit ? first_ivl  : act_ivl[nidx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q       <= 1'b0;
      idx_q       <= '0;
      remain_q    <= '0;
      gate_open_q <= '1;
      evt_q       <= 1'b0;
      err_zero_q  <= 1'b0;
      err_col_q   <= 1'b0;
    end else begin
      evt_q <= fire_c;
      if (!run_en) begin
        run_q       <= 1'b0;
        idx_q       <= '0;
        remain_q    <= '0;
        gate_open_q <= '1;
      end else if (fire_c) begin
        run_q       <= 1'b1;
        idx_q       <= nidx;
        remain_q    <= IVL_W'(tas_pkg::eff_slots(32'(livl)));
        gate_open_q <= lmask;
      end else if (run_q && slot_strobe) begin
        remain_q <= remain_q - IVL_W'(1);
      end
      if (fire_c && livl == '0)     err_zero_q <= 1'b1;
      if (fire_c && peer_gate_evt)  err_col_q  <= 1'b1;
    end
  end

  // R4: gates are frozen between slot strobes while armed
  p_gates_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !slot_strobe) |=> $stable(gate_open_q));
  // R4: a running entry always has at least one slot left
  p_remain_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> remain_q != '0);
  // R2: no start on a strobe before the start slot
  p_no_early_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !(slot_strobe && now_slot >= base_slot)) |=> !run_q);
  // R5: entry index never leaves the active list
  p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> idx_q <= act_len_m1);
  // R9: event pulse only after a strobe
  p_evt_after_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |-> $past(slot_strobe));
  // R7 and R8: error flags are sticky
  p_zero_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_zero_q |=> err_zero_q);
  p_col_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_col_q |=> err_col_q);
endmodule

// File: rtl/tas_egress_gate_sched.sv
module tas_egress_gate_sched #(
  parameter int NUM_TC      = 8,
  parameter int MAX_ENTRIES = 16,
  parameter int IVL_W       = 16,
  parameter int TIME_W      = 32,
  localparam int IDX_W      = $clog2(MAX_ENTRIES),
  localparam int ADDR_W     = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_strobe,
  input  logic [TIME_W-1:0] now_slot,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              peer_gate_evt,
  output logic [NUM_TC-1:0] gate_open,
  output logic              gate_evt,
  output logic [IDX_W-1:0]  cur_entry,
  output logic              running,
  output logic              err_zero_ivl,
  output logic              err_collision
);
  logic [MAX_ENTRIES-1:0][NUM_TC-1:0] sh_mask, act_mask;
  logic [MAX_ENTRIES-1:0][IVL_W-1:0]  sh_ivl, act_ivl;
  logic [IDX_W-1:0]                   sh_len_m1, act_len_m1;
  logic                               run_en, commit;
  logic [TIME_W-1:0]                  base_slot;

  tas_gcl_shadow #(.NUM_TC(NUM_TC), .MAX_ENTRIES(MAX_ENTRIES), .IVL_W(IVL_W), .TIME_W(TIME_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .sh_mask(sh_mask), .sh_ivl(sh_ivl), .sh_len_m1(sh_len_m1), .run_en(run_en), .base_slot(base_slot));

  tas_gcl_active #(.NUM_TC(NUM_TC), .MAX_ENTRIES(MAX_ENTRIES), .IVL_W(IVL_W)) u_active (
    .clk(clk), .rst_n(rst_n), .commit(commit), .sh_mask(sh_mask), .sh_ivl(sh_ivl),
    .sh_len_m1(sh_len_m1), .act_mask(act_mask), .act_ivl(act_ivl), .act_len_m1(act_len_m1));

  tas_gate_engine #(.NUM_TC(NUM_TC), .MAX_ENTRIES(MAX_ENTRIES), .IVL_W(IVL_W), .TIME_W(TIME_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .slot_strobe(slot_strobe), .now_slot(now_slot),
    .base_slot(base_slot), .peer_gate_evt(peer_gate_evt), .first_mask(sh_mask[0]), .first_ivl(sh_ivl[0]),
    .act_mask(act_mask), .act_ivl(act_ivl), .act_len_m1(act_len_m1), .commit(commit),
    .gate_open_q(gate_open), .evt_q(gate_evt), .idx_q(cur_entry), .run_q(running),
    .err_zero_q(err_zero_ivl), .err_col_q(err_collision));
endmodule

// File: tb/tas_egress_gate_sched_tb.sv
module tas_egress_gate_sched_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slot_strobe = 1'b0;
  logic [31:0] now_slot = '0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        peer_gate_evt = 1'b0;
  logic [7:0]  gate_open;
  logic        gate_evt;
  logic [3:0]  cur_entry;
  logic        running, err_zero_ivl, err_collision;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tas_egress_gate_sched u_dut (
    .clk(clk), .rst_n(rst_n), .slot_strobe(slot_strobe), .now_slot(now_slot),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .peer_gate_evt(peer_gate_evt),
    .gate_open(gate_open), .gate_evt(gate_evt), .cur_entry(cur_entry), .running(running),
    .err_zero_ivl(err_zero_ivl), .err_collision(err_collision));

  localparam logic [4:0] A_CTL = 5'd16, A_LEN = 5'd17, A_BASE = 5'd18;

  // {slot, expected gate_open, expected gate_evt, expected cur_entry}
  // list: e0 = 0x80 x2, e1 = 0x7F x3, e2 = 0x05 x1, start slot 10
  localparam logic [28:0] VEC [12] = '{
    {16'd8,  8'hFF, 1'b0, 4'd0}, {16'd9,  8'hFF, 1'b0, 4'd0},
    {16'd10, 8'h80, 1'b1, 4'd0}, {16'd11, 8'h80, 1'b0, 4'd0},
    {16'd12, 8'h7F, 1'b1, 4'd1}, {16'd13, 8'h7F, 1'b0, 4'd1},
    {16'd14, 8'h7F, 1'b0, 4'd1}, {16'd15, 8'h05, 1'b1, 4'd2},
    {16'd16, 8'h80, 1'b1, 4'd0}, {16'd17, 8'h80, 1'b0, 4'd0},
    {16'd18, 8'h7F, 1'b1, 4'd1}, {16'd19, 8'h7F, 1'b0, 4'd1}};

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] ent(input int ivl, input int mask);
    ent = (32'(ivl) << 8) | 32'(mask);
  endfunction

  task automatic strobe(input int slot, input bit peer);
    @(negedge clk);
    slot_strobe = 1'b1; now_slot = 32'(slot); peer_gate_evt = peer;
    @(negedge clk);
    slot_strobe = 1'b0; peer_gate_evt = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "gate_open", 32'(gate_open), 32'hFF);
    chk("R1", "running", 32'(running), 0);
    chk("R1", "gate_evt", 32'(gate_evt), 0);
    chk("R1", "errors", 32'({err_zero_ivl, err_collision}), 0);
    chk("R1", "cur_entry", 32'(cur_entry), 0);

    // R11 register map programming
    wr(5'd0, ent(2, 8'h80));
    wr(5'd1, ent(3, 8'h7F));
    wr(5'd2, ent(1, 8'h05));
    wr(A_LEN, 32'd2);
    wr(A_BASE, 32'd10);
    wr(A_CTL, 32'd1);

    // R2 R3 R4 R5 R9 R11: walk the vector table
    for (int i = 0; i < 12; i++) begin
      strobe(int'(VEC[i][28:13]), 1'b0);
      chk("R3_R5_R11", $sformatf("gate slot %0d", VEC[i][28:13]), 32'(gate_open), 32'(VEC[i][12:5]));
      chk("R9", $sformatf("evt slot %0d", VEC[i][28:13]), 32'(gate_evt), 32'(VEC[i][4]));
      chk("R5", $sformatf("entry slot %0d", VEC[i][28:13]), 32'(cur_entry), 32'(VEC[i][3:0]));
      chk("R2", $sformatf("running slot %0d", VEC[i][28:13]), 32'(running), (VEC[i][28:13] >= 16'd10) ? 1 : 0);
    end

    // R4: no strobe, no change
    repeat (3) @(negedge clk);
    chk("R4", "gate hold", 32'(gate_open), 32'h7F);
    chk("R9", "evt idle", 32'(gate_evt), 0);

    // R6: rewrite mid-cycle
    wr(5'd1, ent(3, 8'h33));
    wr(A_LEN, 32'd1);
    strobe(20, 1'b0); chk("R6", "old e1 kept", 32'(gate_open), 32'h7F);
    strobe(21, 1'b0); chk("R6", "old e2 still runs", 32'(gate_open), 32'h05);
    chk("R6", "old length", 32'(cur_entry), 2);
    strobe(22, 1'b0); chk("R6", "wrap e0", 32'(gate_open), 32'h80);
    strobe(23, 1'b0);
    strobe(24, 1'b0); chk("R6", "new e1 mask", 32'(gate_open), 32'h33);
    // R8: peer event without local event
    strobe(25, 1'b1); chk("R8", "peer alone", 32'(err_collision), 0);
    strobe(26, 1'b0);
    strobe(27, 1'b1); chk("R6", "new length wrap", 32'(cur_entry), 0);
    chk("R8", "collision", 32'(err_collision), 1);

    // R7: zero interval, deferred to next cycle
    wr(5'd1, ent(0, 8'h11));
    strobe(28, 1'b0);
    strobe(29, 1'b0); chk("R6", "active e1 unchanged", 32'(gate_open), 32'h33);
    strobe(30, 1'b0); strobe(31, 1'b0);
    strobe(32, 1'b0); chk("R5", "wrap", 32'(cur_entry), 0);
    strobe(33, 1'b0); chk("R7", "no flag yet", 32'(err_zero_ivl), 0);
    strobe(34, 1'b0); chk("R7", "zero entry mask", 32'(gate_open), 32'h11);
    chk("R7", "zero flag", 32'(err_zero_ivl), 1);
    strobe(35, 1'b0); chk("R7", "one slot only", 32'(gate_open), 32'h80);
    chk("R8", "sticky", 32'(err_collision), 1);

    // R10: stop and rearm
    wr(A_CTL, 32'd0);
    @(negedge clk);
    chk("R10", "gates open", 32'(gate_open), 32'hFF);
    chk("R10", "stopped", 32'(running), 0);
    wr(A_BASE, 32'd100);
    wr(A_CTL, 32'd1);
    strobe(50, 1'b0); chk("R2", "wait base", 32'(gate_open), 32'hFF);
    strobe(99, 1'b0); chk("R2", "one before base", 32'(running), 0);
    strobe(100, 1'b0); chk("R10", "restart e0", 32'(gate_open), 32'h80);
    chk("R10", "restart entry", 32'(cur_entry), 0);
    chk("R9", "restart evt", 32'(gate_evt), 1);
    @(negedge clk);
    chk("R9", "pulse one clock", 32'(gate_evt), 0);

    finish_run();
  end
endmodule